// File: doc/BRIEF.md
# Asynchronous Two-Way Mailbox Bridge

This block sits between a host processor bus and a coprocessor bus whose clocks have no fixed relation. Each direction has its own set of three data bytes and a three-bit flag field. A write on one side is only ever seen by reads on the other side. Neither side can read back what it wrote, because a read of a mailbox location returns the last value that the opposite side published. Software on the two processors orders its messages by toggling flag bits and polling for the partner's reply.

Flags cross the clock boundary through a two-flop synchroniser. A small receive state machine in the reading domain decides when new data is published. It has two states. In `RX_IDLE` it compares the synchronised flags with the flags it currently shows. When they differ it takes the transition `RX_IDLE -> RX_LOAD`. When they match it stays in `RX_IDLE`. In `RX_LOAD` it copies the writer's three data bytes and the synchronised flags into the visible registers, then always returns to `RX_IDLE`.

The host window also gives a live view of eight input pins and a view of a 6-bit free-running counter clocked by a separate fast clock. Locations that drive nothing return open bus, which is the last byte that moved on that side's bus. The upstream chip-enable decoder that mirrors the host window across its address range lies outside this block. Only the three low address bits reach it.

Top module: `mbx_bridge`

## Requirements
- R1: After reset, every mailbox data byte reads 0x00 on both sides. Every flag field reads 111 in bits 7:5, and the open-bus byte is 0x00.
- R2: Host offsets 0, 1 and 2 are data bytes the host sends. They are read by the coprocessor at its offsets 3, 4 and 5. Bits 7:5 of a host write to offset 3 are the host-to-coprocessor flags. The coprocessor reads them in bits 7:5 of its offset 2.
- R3: Coprocessor writes to offsets 3, 4 and 5 are data bytes. The host reads them at offsets 0, 1 and 2. Bits 7:5 of a coprocessor write to offset 2 are flags, which the host reads in bits 7:5 of its offset 3.
- R4: A read of a mailbox location never returns the reading side's own write. It returns the value last published from the other side.
- R5: A flag change is published exactly four reader-clock rising edges after the writer-clock edge that stored it. The three data bytes are published together with it. Before that fourth edge the reader sees the old flags and the old data.
- R6: Data bytes written with no later flag change never become visible to the other side. This also holds when the flag field is rewritten with an unchanged value.
- R7: Bits 4:0 of each flag location read as that side's open-bus byte.
- R8: Each side holds an open-bus byte. It is the data of the last write, or the value returned by the last read, on that side's bus. Host offsets 6 and 7, and coprocessor offsets 0, 1, 6 and 7, read back this byte.
- R9: Host offset 4 returns the eight input pin levels, delayed by a two-stage synchroniser.
- R10: Host offset 5 returns 0 in bits 7:6. Bits 5:0 hold a counter that advances on every fast-clock edge, so two reads spaced ten host cycles apart differ.
- R11: The receive state machine stays in `RX_LOAD` for exactly one cycle. The visible flags and data change only on the edge that leaves `RX_LOAD`.
- R12: Writes to host offsets 4 to 7, and to coprocessor offsets 0, 1, 6 and 7, change only the open-bus byte. No mailbox byte, flag, pin view or counter view changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Active-low asynchronous reset for all domains |
| host_clk | input | 1 | Host bus clock |
| host_sel | input | 1 | Host chip enable from the upstream decoder |
| host_addr | input | 3 | Host register offset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data |
| host_pins | input | 8 | Live status pins shown at host offset 4 |
| fast_clk | input | 1 | Clock for the free-running counter |
| cop_clk | input | 1 | Coprocessor bus clock |
| cop_sel | input | 1 | Coprocessor select for the mailbox block |
| cop_addr | input | 3 | Coprocessor register offset |
| cop_wr | input | 1 | Coprocessor write strobe |
| cop_rd | input | 1 | Coprocessor read strobe |
| cop_wdata | input | 8 | Coprocessor write data |
| cop_rdata | output | 8 | Coprocessor read data |

## Verification
A receive state machine that misses a flag change, or that loads without one, shows a mailbox read holding stale bytes. It can also show bytes that were never flagged. The wrong value appears on the first read on that side once the four-edge publication delay has passed. A load one edge early or late shows up as a flag byte that changes on the wrong host or coprocessor read. Reads are issued back to back straight after each flag write, so the edge on which each change appears is pinned. A wrong open-bus byte appears on the very next read of an unmapped location, or in the low five bits of the next flag read.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    typedef enum logic [0:0] {
        RX_IDLE = 1'b0,
        RX_LOAD = 1'b1
    } rx_state_e;

endpackage

// File: rtl/mbx_sync.sv
module mbx_sync #(
    parameter int              W       = 1,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= RST_VAL;
        end else begin
            stage_q[0] <= d;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign q = stage_q[STAGES-1];

endmodule

// File: rtl/mbx_fast_cnt.sv
module mbx_fast_cnt #(
    parameter int CNT_W  = 6,
    parameter int STAGES = 2
) (
    input  logic             fast_clk,
    input  logic             rd_clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] count
);

    logic [CNT_W-1:0] bin_q;
    logic [CNT_W-1:0] gray_q;
    logic [CNT_W-1:0] gray_s;

    always_ff @(posedge fast_clk or negedge rst_n) begin
        if (!rst_n) begin
            bin_q  <= '0;
            gray_q <= '0;
        end else begin
            bin_q  <= bin_q + 1'b1;
            gray_q <= bin_q ^ (bin_q >> 1);
        end
    end

    mbx_sync #(.W(CNT_W), .STAGES(STAGES), .RST_VAL('0)) u_gray_sync (
        .clk   (rd_clk),
        .rst_n (rst_n),
        .d     (gray_q),
        .q     (gray_s)
    );

    always_comb begin
        count[CNT_W-1] = gray_s[CNT_W-1];
        for (int i = CNT_W - 2; i >= 0; i--) count[i] = count[i+1] ^ gray_s[i];
    end

endmodule

// File: rtl/mbx_dir_rx.sv
module mbx_dir_rx
    import mbx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int NBYTES = 3,
    parameter int FLAG_N = 3,
    parameter int STAGES = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [FLAG_N-1:0]        src_flags,
    input  logic [NBYTES*DATA_W-1:0] src_data,
    output logic [FLAG_N-1:0]        vis_flags,
    output logic [NBYTES*DATA_W-1:0] vis_data,
    output logic                     loading
);

    rx_state_e         state_q;
    rx_state_e         state_d;
    logic [FLAG_N-1:0] flags_s;

    mbx_sync #(.W(FLAG_N), .STAGES(STAGES), .RST_VAL('1)) u_flag_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (src_flags),
        .q     (flags_s)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_IDLE: if (flags_s != vis_flags) state_d = RX_LOAD;
            RX_LOAD: state_d = RX_IDLE;
            default: state_d = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RX_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vis_flags <= '1;
            vis_data  <= '0;
        end else if (state_q == RX_LOAD) begin
            vis_flags <= flags_s;
            vis_data  <= src_data;
        end
    end

    assign loading = (state_q == RX_LOAD);

endmodule

// File: rtl/mbx_bridge.sv
module mbx_bridge #(
    parameter int DATA_W      = 8,
    parameter int SEL_W       = 3,
    parameter int NBYTES      = 3,
    parameter int FLAG_N      = 3,
    parameter int CNT_W       = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic              rst_n,
    input  logic              host_clk,
    input  logic              host_sel,
    input  logic [SEL_W-1:0]  host_addr,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    input  logic [DATA_W-1:0] host_pins,
    input  logic              fast_clk,
    input  logic              cop_clk,
    input  logic              cop_sel,
    input  logic [SEL_W-1:0]  cop_addr,
    input  logic              cop_wr,
    input  logic              cop_rd,
    input  logic [DATA_W-1:0] cop_wdata,
    output logic [DATA_W-1:0] cop_rdata
);

    localparam int BUS_W    = NBYTES * DATA_W;
    localparam int FLAG_LSB = DATA_W - FLAG_N;
    localparam logic [SEL_W-1:0] H_FLAG = SEL_W'(NBYTES);
    localparam logic [SEL_W-1:0] H_PIN  = SEL_W'(NBYTES + 1);
    localparam logic [SEL_W-1:0] H_CNT  = SEL_W'(NBYTES + 2);
    localparam logic [SEL_W-1:0] C_FLAG = SEL_W'(2);
    localparam logic [SEL_W-1:0] C_BASE = SEL_W'(3);

    logic [BUS_W-1:0]  h2c_src;
    logic [FLAG_N-1:0] h2c_src_flags;
    logic [BUS_W-1:0]  c2h_src;
    logic [FLAG_N-1:0] c2h_src_flags;
    logic [BUS_W-1:0]  h2c_vis_data;
    logic [FLAG_N-1:0] h2c_vis_flags;
    logic [BUS_W-1:0]  c2h_vis_data;
    logic [FLAG_N-1:0] c2h_vis_flags;
    logic              h2c_loading;
    logic              c2h_loading;
    logic [DATA_W-1:0] host_ob;
    logic [DATA_W-1:0] cop_ob;
    logic [DATA_W-1:0] pins_s;
    logic [CNT_W-1:0]  fast_cnt;

    // host side: writer of the host-to-coprocessor direction
    always_ff @(posedge host_clk or negedge rst_n) begin
        if (!rst_n) begin
            h2c_src       <= '0;
            h2c_src_flags <= '1;
        end else if (host_sel && host_wr) begin
            for (int b = 0; b < NBYTES; b++) begin
                if (host_addr == SEL_W'(b)) h2c_src[b*DATA_W +: DATA_W] <= host_wdata;
            end
            if (host_addr == H_FLAG) h2c_src_flags <= host_wdata[DATA_W-1:FLAG_LSB];
        end
    end

    always_ff @(posedge host_clk or negedge rst_n) begin
        if (!rst_n)                   host_ob <= '0;
        else if (host_sel && host_wr) host_ob <= host_wdata;
        else if (host_sel && host_rd) host_ob <= host_rdata;
    end

    // coprocessor side: writer of the coprocessor-to-host direction
    always_ff @(posedge cop_clk or negedge rst_n) begin
        if (!rst_n) begin
            c2h_src       <= '0;
            c2h_src_flags <= '1;
        end else if (cop_sel && cop_wr) begin
            for (int b = 0; b < NBYTES; b++) begin
                if (cop_addr == C_BASE + SEL_W'(b)) c2h_src[b*DATA_W +: DATA_W] <= cop_wdata;
            end
            if (cop_addr == C_FLAG) c2h_src_flags <= cop_wdata[DATA_W-1:FLAG_LSB];
        end
    end

    always_ff @(posedge cop_clk or negedge rst_n) begin
        if (!rst_n)                 cop_ob <= '0;
        else if (cop_sel && cop_wr) cop_ob <= cop_wdata;
        else if (cop_sel && cop_rd) cop_ob <= cop_rdata;
    end

    // receivers, one per direction, in the reading clock domain
    mbx_dir_rx #(.DATA_W(DATA_W), .NBYTES(NBYTES), .FLAG_N(FLAG_N), .STAGES(SYNC_STAGES)) u_h2c_rx (
        .clk       (cop_clk),
        .rst_n     (rst_n),
        .src_flags (h2c_src_flags),
        .src_data  (h2c_src),
        .vis_flags (h2c_vis_flags),
        .vis_data  (h2c_vis_data),
        .loading   (h2c_loading)
    );

    mbx_dir_rx #(.DATA_W(DATA_W), .NBYTES(NBYTES), .FLAG_N(FLAG_N), .STAGES(SYNC_STAGES)) u_c2h_rx (
        .clk       (host_clk),
        .rst_n     (rst_n),
        .src_flags (c2h_src_flags),
        .src_data  (c2h_src),
        .vis_flags (c2h_vis_flags),
        .vis_data  (c2h_vis_data),
        .loading   (c2h_loading)
    );

    mbx_sync #(.W(DATA_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_pin_sync (
        .clk   (host_clk),
        .rst_n (rst_n),
        .d     (host_pins),
        .q     (pins_s)
    );

    mbx_fast_cnt #(.CNT_W(CNT_W), .STAGES(SYNC_STAGES)) u_fast_cnt (
        .fast_clk (fast_clk),
        .rd_clk   (host_clk),
        .rst_n    (rst_n),
        .count    (fast_cnt)
    );

    // read selection
    always_comb begin
        host_rdata = host_ob;
        for (int b = 0; b < NBYTES; b++) begin
            if (host_addr == SEL_W'(b)) host_rdata = c2h_vis_data[b*DATA_W +: DATA_W];
        end
        if (host_addr == H_FLAG) host_rdata = {c2h_vis_flags, host_ob[FLAG_LSB-1:0]};
        if (host_addr == H_PIN)  host_rdata = pins_s;
        if (host_addr == H_CNT)  host_rdata = {{(DATA_W-CNT_W){1'b0}}, fast_cnt};
    end

    always_comb begin
        cop_rdata = cop_ob;
        for (int b = 0; b < NBYTES; b++) begin
            if (cop_addr == C_BASE + SEL_W'(b)) cop_rdata = h2c_vis_data[b*DATA_W +: DATA_W];
        end
        if (cop_addr == C_FLAG) cop_rdata = {h2c_vis_flags, cop_ob[FLAG_LSB-1:0]};
    end

endmodule

// File: rtl/mbx_bridge_chk.sv
module mbx_bridge_chk #(
    parameter int DATA_W = 8,
    parameter int SEL_W  = 3,
    parameter int NBYTES = 3,
    parameter int FLAG_N = 3
) (
    input logic                     rst_n,
    input logic                     host_clk,
    input logic                     host_sel,
    input logic [SEL_W-1:0]         host_addr,
    input logic                     host_wr,
    input logic                     host_rd,
    input logic [DATA_W-1:0]        host_wdata,
    input logic [DATA_W-1:0]        host_rdata,
    input logic                     cop_clk,
    input logic                     cop_sel,
    input logic [SEL_W-1:0]         cop_addr,
    input logic                     cop_wr,
    input logic                     cop_rd,
    input logic [DATA_W-1:0]        cop_wdata,
    input logic [DATA_W-1:0]        cop_rdata,
    input logic                     h2c_loading,
    input logic                     c2h_loading,
    input logic [FLAG_N-1:0]        h2c_vis_flags,
    input logic [NBYTES*DATA_W-1:0] h2c_vis_data,
    input logic [FLAG_N-1:0]        c2h_vis_flags,
    input logic [NBYTES*DATA_W-1:0] c2h_vis_data
);

    localparam int OB_W = DATA_W - FLAG_N;

    // R8
    host_open_bus_chk: assert property (@(posedge host_clk) disable iff (!rst_n)
        (host_sel && host_wr) |=>
        (!(host_sel && host_rd && host_addr == SEL_W'(7)) || host_rdata == $past(host_wdata)));

    // R8
    cop_open_bus_chk: assert property (@(posedge cop_clk) disable iff (!rst_n)
        (cop_sel && cop_wr) |=>
        (!(cop_sel && cop_rd && cop_addr == SEL_W'(0)) || cop_rdata == $past(cop_wdata)));

    // R7
    host_flag_low_chk: assert property (@(posedge host_clk) disable iff (!rst_n)
        ($past(host_sel && host_wr) && host_sel && host_rd && host_addr == SEL_W'(3)) |->
        host_rdata[OB_W-1:0] == $past(host_wdata[OB_W-1:0]));

    // R10
    cnt_upper_zero_chk: assert property (@(posedge host_clk) disable iff (!rst_n)
        (host_sel && host_rd && host_addr == SEL_W'(5)) |-> host_rdata[DATA_W-1:DATA_W-2] == 2'b00);

    // R11
    c2h_load_pulse_chk: assert property (@(posedge host_clk) disable iff (!rst_n)
        c2h_loading |=> !c2h_loading);

    // R11
    h2c_load_pulse_chk: assert property (@(posedge cop_clk) disable iff (!rst_n)
        h2c_loading |=> !h2c_loading);

    // R6
    c2h_hold_chk: assert property (@(posedge host_clk) disable iff (!rst_n)
        !c2h_loading |=> ($stable(c2h_vis_flags) && $stable(c2h_vis_data)));

    // R6
    h2c_hold_chk: assert property (@(posedge cop_clk) disable iff (!rst_n)
        !h2c_loading |=> ($stable(h2c_vis_flags) && $stable(h2c_vis_data)));

endmodule

bind mbx_bridge mbx_bridge_chk #(
    .DATA_W (DATA_W),
    .SEL_W  (SEL_W),
    .NBYTES (NBYTES),
    .FLAG_N (FLAG_N)
) u_chk (.*);

// File: tb/tb_mbx_bridge.sv
module tb_mbx_bridge;

    localparam int HOST_PERIOD = 10;
    localparam int COP_PERIOD  = 16;
    localparam int FAST_PERIOD = 6;

    logic       rst_n = 1'b0;
    logic       host_clk = 1'b0;
    logic       cop_clk = 1'b0;
    logic       fast_clk = 1'b0;
    logic       host_sel = 1'b0, host_wr = 1'b0, host_rd = 1'b0;
    logic [2:0] host_addr = '0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic [7:0] host_pins = 8'h00;
    logic       cop_sel = 1'b0, cop_wr = 1'b0, cop_rd = 1'b0;
    logic [2:0] cop_addr = '0;
    logic [7:0] cop_wdata = '0;
    logic [7:0] cop_rdata;

    int tests = 0;
    int fails = 0;

    // reference model state
    logic [7:0] h2c_wd [3], h2c_pd [3], h2c_vd [3];
    logic [7:0] c2h_wd [3], c2h_pd [3], c2h_vd [3];
    logic [2:0] h2c_wf = 3'b111, h2c_pf, h2c_vf = 3'b111;
    logic [2:0] c2h_wf = 3'b111, c2h_pf, c2h_vf = 3'b111;
    bit         h2c_pend = 0, c2h_pend = 0;
    int         h2c_cnt = 0, c2h_cnt = 0;
    logic [7:0] host_ob = 8'h00, cop_ob = 8'h00;
    logic [5:0] last_cnt;

    mbx_bridge dut (
        .rst_n, .host_clk, .host_sel, .host_addr, .host_wr, .host_rd,
        .host_wdata, .host_rdata, .host_pins, .fast_clk, .cop_clk,
        .cop_sel, .cop_addr, .cop_wr, .cop_rd, .cop_wdata, .cop_rdata
    );

    always #(HOST_PERIOD/2) host_clk = ~host_clk;
    always #(FAST_PERIOD/2) fast_clk = ~fast_clk;
    initial begin
        #4;
        forever begin cop_clk = 1'b1; #(COP_PERIOD/2); cop_clk = 1'b0; #(COP_PERIOD/2); end
    end

    // publication after four reader edges (R5)
    always @(posedge cop_clk) if (h2c_pend) begin
        h2c_cnt++;
        if (h2c_cnt == 4) begin h2c_vd = h2c_pd; h2c_vf = h2c_pf; h2c_pend = 0; end
    end
    always @(posedge host_clk) if (c2h_pend) begin
        c2h_cnt++;
        if (c2h_cnt == 4) begin c2h_vd = c2h_pd; c2h_vf = c2h_pf; c2h_pend = 0; end
    end

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got %h expected %h", req, got, exp);
        end
    endtask

    function automatic logic [7:0] host_exp(input logic [2:0] a);
        case (a)
            3'd0, 3'd1, 3'd2: return c2h_vd[a];
            3'd3:             return {c2h_vf, host_ob[4:0]};
            3'd4:             return host_pins;
            default:          return host_ob;
        endcase
    endfunction

    function automatic logic [7:0] cop_exp(input logic [2:0] a);
        case (a)
            3'd2:             return {h2c_vf, cop_ob[4:0]};
            3'd3, 3'd4, 3'd5: return h2c_vd[a-3];
            default:          return cop_ob;
        endcase
    endfunction

    task automatic host_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge host_clk);
        host_sel = 1; host_wr = 1; host_addr = a; host_wdata = d;
        @(posedge host_clk);
        host_ob = d;
        if (a < 3) h2c_wd[a] = d;
        else if (a == 3) begin
            if (d[7:5] != h2c_wf) begin
                h2c_pd = h2c_wd; h2c_pf = d[7:5]; h2c_cnt = 0; h2c_pend = 1;
            end
            h2c_wf = d[7:5];
        end
        @(negedge host_clk);
        host_sel = 0; host_wr = 0;
    endtask

    task automatic cop_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge cop_clk);
        cop_sel = 1; cop_wr = 1; cop_addr = a; cop_wdata = d;
        @(posedge cop_clk);
        cop_ob = d;
        if (a >= 3 && a <= 5) c2h_wd[a-3] = d;
        else if (a == 2) begin
            if (d[7:5] != c2h_wf) begin
                c2h_pd = c2h_wd; c2h_pf = d[7:5]; c2h_cnt = 0; c2h_pend = 1;
            end
            c2h_wf = d[7:5];
        end
        @(negedge cop_clk);
        cop_sel = 0; cop_wr = 0;
    endtask

    task automatic host_read(input logic [2:0] a, input string req);
        logic [7:0] got;
        @(negedge host_clk);
        host_sel = 1; host_rd = 1; host_addr = a;
        #1;
        got = host_rdata;
        if (a == 3'd5) begin
            check(req, got & 8'hC0, 8'h00);
            last_cnt = got[5:0];
        end else check(req, got, host_exp(a));
        @(posedge host_clk);
        host_ob = got;
        @(negedge host_clk);
        host_sel = 0; host_rd = 0;
    endtask

    task automatic cop_read(input logic [2:0] a, input string req);
        logic [7:0] got;
        @(negedge cop_clk);
        cop_sel = 1; cop_rd = 1; cop_addr = a;
        #1;
        got = cop_rdata;
        check(req, got, cop_exp(a));
        @(posedge cop_clk);
        cop_ob = got;
        @(negedge cop_clk);
        cop_sel = 0; cop_rd = 0;
    endtask

    initial begin
        #(HOST_PERIOD * 100000);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [5:0] first_cnt;
        for (int i = 0; i < 3; i++) begin
            h2c_wd[i] = 0; h2c_vd[i] = 0; c2h_wd[i] = 0; c2h_vd[i] = 0;
        end
        #101 rst_n = 1'b1;
        repeat (3) @(posedge host_clk);

        // R1: reset state on both sides
        for (int a = 0; a < 4; a++) host_read(3'(a), "R1 host reset");
        for (int a = 2; a < 6; a++) cop_read(3'(a), "R1 cop reset");

        // R2 and R5: host to coprocessor, polled straight after the flag write
        host_write(0, 8'hA1); host_write(1, 8'hB2); host_write(2, 8'hC3);
        host_write(3, 8'h60);
        for (int i = 0; i < 4; i++) cop_read(2, "R5 h2c flag timing");
        for (int a = 3; a < 6; a++) cop_read(3'(a), "R2 h2c data");

        // R4: the host does not see its own bytes
        for (int a = 0; a < 4; a++) host_read(3'(a), "R4 host no readback");

        // R3 and R5: coprocessor to host
        cop_write(3, 8'h11); cop_write(4, 8'h22); cop_write(5, 8'h33);
        cop_write(2, 8'h40);
        for (int i = 0; i < 5; i++) host_read(3, "R5 c2h flag timing");
        for (int a = 0; a < 3; a++) host_read(3'(a), "R3 c2h data");
        for (int a = 3; a < 6; a++) cop_read(3'(a), "R4 cop no readback");

        // R6: unflagged data and unchanged flag rewrite stay hidden
        host_write(0, 8'h5A);
        host_write(3, 8'h60);
        repeat (10) @(posedge cop_clk);
        cop_read(3, "R6 unflagged hidden");
        host_write(3, 8'hE0);
        repeat (6) @(posedge cop_clk);
        cop_read(3, "R6 flagged now visible");
        cop_read(2, "R6 flag visible");

        // R7 and R8: open bus on both sides
        host_write(7, 8'h1F);
        host_read(7, "R8 host open bus");
        host_read(3, "R7 host flag low bits");
        host_read(6, "R8 host offset 6");
        cop_write(0, 8'h3C);
        cop_read(0, "R8 cop open bus");
        cop_read(2, "R7 cop flag low bits");
        cop_read(7, "R8 cop offset 7");

        // R9: pin view
        host_pins = 8'h96;
        repeat (4) @(posedge host_clk);
        host_read(4, "R9 pins 96");
        host_pins = 8'h69;
        repeat (4) @(posedge host_clk);
        host_read(4, "R9 pins 69");

        // R10: counter view
        host_read(5, "R10 counter upper bits");
        first_cnt = last_cnt;
        repeat (10) @(posedge host_clk);
        host_read(5, "R10 counter upper bits");
        tests++;
        if (first_cnt == last_cnt) begin
            fails++;
            $display("FAIL R10 counter got %h expected a change from %h", last_cnt, first_cnt);
        end

        // R12: writes to non-mailbox locations touch only open bus
        host_write(4, 8'hFF); host_write(5, 8'hFF); host_write(6, 8'h07);
        host_read(4, "R12 pins unchanged");
        host_read(0, "R12 host data unchanged");
        cop_write(0, 8'hEE); cop_write(1, 8'hDD); cop_write(6, 8'hCC); cop_write(7, 8'hBB);
        cop_write(2, 8'h20);
        repeat (6) @(posedge host_clk);
        for (int a = 0; a < 4; a++) host_read(3'(a), "R12 c2h data unchanged");
        for (int a = 3; a < 6; a++) cop_read(3'(a), "R12 h2c data unchanged");

        // R11: back-to-back flag changes each publish once
        cop_write(2, 8'hA0);
        for (int i = 0; i < 5; i++) host_read(3, "R11 load once");
        host_write(3, 8'h00);
        for (int i = 0; i < 4; i++) cop_read(2, "R11 load once");

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule